// File: doc/BRIEF.md
# Timed DMA Byte-Transfer Controller

This block sequences one DMA transfer session. A start pulse opens a session: the controller raises a request level towards the DMA engine and holds it until the grant comes back. From the cycle after the grant, each valid input byte is passed to the byte output in the same cycle. An end-of-transfer strobe closes the session with a one-cycle done pulse.

A watchdog timer covers the whole session. It runs from the start pulse. If the session has not closed when the limit is reached, the session is dropped at once and a one-cycle timeout pulse is raised. In that cycle no other output is driven: no request, no byte and no done. The limit is set in microseconds and converted to clock cycles from the clock rate parameter. The controller then goes back to idle and waits for the next start.

Top module: `dma_session_ctrl`

## Requirements
- R1: While reset is asserted, and in idle after reset, every output is low and `byte_o` is zero.
- R2: A start pulse seen in idle makes `req_o` high from the next cycle. `req_o` stays high until the cycle in which `grant_i` is high. In that grant cycle `req_o` is already low, and the session moves to the transfer phase in the next cycle.
- R3: In the transfer phase, every cycle with `byte_vld_i` high and neither end nor timeout drives `byte_vld_o` high, with `byte_o` equal to `byte_i` in the same cycle. No byte is forwarded in the request phase.
- R4: `end_i` in the transfer phase gives a one-cycle `done_o` in the same cycle. A byte presented in that cycle is not forwarded, and the controller is idle from the next cycle.
- R5: Count the first cycle after the accepted start as cycle 0. If the session is still open in cycle LIMIT-1, then in that cycle `timeout_o` pulses for one cycle, `req_o`, `byte_vld_o` and `done_o` stay low, and the controller is idle from the next cycle.
- R6: When `end_i` and the time limit fall in the same cycle, the timeout wins: `timeout_o` is high and `done_o` is low.
- R7: A start pulse during an open session is ignored. It neither restarts the timer nor changes the phase.
- R8: LIMIT equals (CLK_FREQ_HZ / 1,000,000) * LIMIT_US cycles.
- R9: `byte_o` is zero in every cycle in which `byte_vld_o` is low.
- R10: In idle, `grant_i`, `end_i` and input bytes have no effect. No output rises, and no request appears without a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Opens a session when idle |
| grant_i | input | 1 | DMA grant |
| byte_vld_i | input | 1 | Input byte valid |
| byte_i | input | DATA_W | Input byte |
| end_i | input | 1 | End-of-transfer strobe |
| req_o | output | 1 | DMA request level |
| byte_vld_o | output | 1 | Forwarded byte valid |
| byte_o | output | DATA_W | Forwarded byte, zero when not valid |
| done_o | output | 1 | Normal completion pulse |
| timeout_o | output | 1 | Session aborted by the time limit |

## Verification
Every output is decoded combinationally from the phase register and the timer, so a wrong phase shows at the ports in the same cycle. A lost grant leaves `req_o` high. A stuck transfer phase keeps forwarding bytes after done. A skipped transfer phase drops bytes right after the grant. An error in the timer load or count moves the timeout pulse away from cycle LIMIT-1, and that is seen as soon as a session is allowed to expire. Randomised sessions cover grant delays and transfer lengths on both sides of the limit, with stray start pulses mixed in. A cycle-level reference in the bench compares all five outputs in every cycle.

// File: rtl/dma_sess_pkg.sv
package dma_sess_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_XFER = 2'd2
   } sess_state_t;
endpackage

// File: rtl/dma_sess_timer.sv
module dma_sess_timer #(
   parameter int LIMIT_CYC  = 40,
   parameter int CNT_W      = 6,
   parameter bit COUNT_DOWN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic active_i,
   output logic expire_o
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT_CYC - 1);

   logic [CNT_W-1:0] cnt_q;

   generate
      if (COUNT_DOWN) begin : g_down
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          cnt_q <= '0;
            else if (load_i)                     cnt_q <= LAST;
            else if (active_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
         end
         assign expire_o = active_i && (cnt_q == '0);
      end else begin : g_up
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          cnt_q <= '0;
            else if (load_i)                     cnt_q <= '0;
            else if (active_i && cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
         end
         assign expire_o = active_i && (cnt_q == LAST);
      end
   endgenerate

   // independent elapsed-cycle counter for checking the window
   logic [CNT_W-1:0] chk_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        chk_q <= '0;
      else if (load_i)                   chk_q <= '0;
      else if (active_i && chk_q != LAST) chk_q <= chk_q + 1'b1;
   end

   p_expire_not_early_r5: assert property (@(posedge clk) disable iff (!rst_n)
      expire_o |-> (chk_q == LAST));
   p_expire_not_late_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (active_i && chk_q == LAST) |-> expire_o);
endmodule

// File: rtl/dma_sess_fsm.sv
module dma_sess_fsm
   import dma_sess_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start_i,
   input  logic        grant_i,
   input  logic        end_i,
   input  logic        expire_i,
   output sess_state_t state_o,
   output logic        load_o
);
   sess_state_t st_q, st_d;

   assign load_o = (st_q == ST_IDLE) && start_i;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: if (start_i) st_d = ST_REQ;
         ST_REQ: begin
            if (expire_i)      st_d = ST_IDLE;
            else if (grant_i)  st_d = ST_XFER;
         end
         ST_XFER: if (expire_i || end_i) st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign state_o = st_q;

   p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_XFER && start_i && !end_i && !expire_i) |=> (st_q == ST_XFER));
   p_idle_stays_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE && !start_i) |=> (st_q == ST_IDLE));
endmodule

// File: rtl/dma_sess_out.sv
module dma_sess_out
   import dma_sess_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  sess_state_t       state_i,
   input  logic              expire_i,
   input  logic              grant_i,
   input  logic              byte_vld_i,
   input  logic [DATA_W-1:0] byte_i,
   input  logic              end_i,
   output logic              req_o,
   output logic              byte_vld_o,
   output logic [DATA_W-1:0] byte_o,
   output logic              done_o,
   output logic              timeout_o
);
   logic in_req, in_xfer, fwd;

   assign in_req     = (state_i == ST_REQ);
   assign in_xfer    = (state_i == ST_XFER);
   assign req_o      = in_req && !grant_i && !expire_i;
   assign fwd        = in_xfer && byte_vld_i && !end_i && !expire_i;
   assign byte_vld_o = fwd;
   assign byte_o     = fwd ? byte_i : '0;
   assign done_o     = in_xfer && end_i && !expire_i;
   assign timeout_o  = expire_i;

   p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && !timeout_o) |=> (req_o || grant_i || timeout_o));
   p_fwd_same_r3: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld_o |-> (byte_vld_i && byte_o == byte_i && !end_i));
   p_abort_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |-> (!req_o && !byte_vld_o && !done_o));
   p_done_then_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!done_o && !byte_vld_o && !timeout_o && !req_o));
   p_exclusive_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done_o, timeout_o}));
   p_zero_idle_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_vld_o |-> (byte_o == '0));
endmodule

// File: rtl/dma_session_ctrl.sv
module dma_session_ctrl
   import dma_sess_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int CLK_FREQ_HZ = 125_000_000,
   parameter int LIMIT_US    = 10_000,
   parameter bit COUNT_DOWN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              grant_i,
   input  logic              byte_vld_i,
   input  logic [DATA_W-1:0] byte_i,
   input  logic              end_i,
   output logic              req_o,
   output logic              byte_vld_o,
   output logic [DATA_W-1:0] byte_o,
   output logic              done_o,
   output logic              timeout_o
);
   localparam int LIMIT_CYC = (CLK_FREQ_HZ / 1_000_000) * LIMIT_US;   // R8
   localparam int CNT_W     = $clog2(LIMIT_CYC + 1);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
      if (LIMIT_CYC < 2) begin : g_bad_limit
         $error("time limit must be at least two cycles");
      end
   endgenerate

   sess_state_t state;
   logic        load, expire;

   dma_sess_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .grant_i  (grant_i),
      .end_i    (end_i),
      .expire_i (expire),
      .state_o  (state),
      .load_o   (load)
   );

   dma_sess_timer #(
      .LIMIT_CYC  (LIMIT_CYC),
      .CNT_W      (CNT_W),
      .COUNT_DOWN (COUNT_DOWN)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load),
      .active_i (state != ST_IDLE),
      .expire_o (expire)
   );

   dma_sess_out #(.DATA_W(DATA_W)) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .state_i    (state),
      .expire_i   (expire),
      .grant_i    (grant_i),
      .byte_vld_i (byte_vld_i),
      .byte_i     (byte_i),
      .end_i      (end_i),
      .req_o      (req_o),
      .byte_vld_o (byte_vld_o),
      .byte_o     (byte_o),
      .done_o     (done_o),
      .timeout_o  (timeout_o)
   );
endmodule

// File: tb/dma_session_ctrl_tb.sv
`timescale 1ns/1ps
module dma_session_ctrl_tb;
   localparam int LIM = 40;   // 2 MHz * 20 us, R8

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       start_i = 0, grant_i = 0, byte_vld_i = 0, end_i = 0;
   logic [7:0] byte_i = '0;
   logic       req_o, byte_vld_o, done_o, timeout_o;
   logic [7:0] byte_o;

   int n_chk = 0, n_fail = 0;
   int m_st  = 0;   // 0 idle, 1 request, 2 transfer
   int m_el  = 0;   // elapsed active cycles

   always #4 clk = ~clk;

   dma_session_ctrl #(.DATA_W(8), .CLK_FREQ_HZ(2_000_000), .LIMIT_US(20)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .grant_i(grant_i),
      .byte_vld_i(byte_vld_i), .byte_i(byte_i), .end_i(end_i),
      .req_o(req_o), .byte_vld_o(byte_vld_o), .byte_o(byte_o),
      .done_o(done_o), .timeout_o(timeout_o));

   function automatic logic exp_to();
      return (m_st != 0) && (m_el == LIM - 1);
   endfunction
   function automatic logic exp_req();
      return (m_st == 1) && !grant_i && !exp_to();
   endfunction
   function automatic logic exp_vld();
      return (m_st == 2) && byte_vld_i && !end_i && !exp_to();
   endfunction
   function automatic logic exp_done();
      return (m_st == 2) && end_i && !exp_to();
   endfunction

   task automatic chk1(input logic act, input logic exp, input string rq, input string ctx);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s (%s) actual=%0b expected=%0b t=%0t", rq, ctx, act, exp, $time);
      end
   endtask

   task automatic cyc(input logic s, g, bv, input logic [7:0] d, input logic e, input string ctx);
      logic [7:0] ed;
      logic       t, dn;
      @(negedge clk);
      start_i = s; grant_i = g; byte_vld_i = bv; byte_i = d; end_i = e;
      #1;
      ed = exp_vld() ? d : 8'h00;
      chk1(req_o, exp_req(), "R2", ctx);
      chk1(byte_vld_o, exp_vld(), "R3", ctx);
      n_chk++;
      if (byte_o !== ed) begin
         n_fail++;
         $display("FAIL R9/R3 (%s) byte actual=%0h expected=%0h", ctx, byte_o, ed);
      end
      chk1(done_o, exp_done(), "R4", ctx);
      chk1(timeout_o, exp_to(), "R5", ctx);
      t  = exp_to();
      dn = exp_done();
      if (m_st == 0) begin
         if (s) begin m_st = 1; m_el = 0; end
      end else if (t || dn) begin
         m_st = 0;
      end else begin
         if (m_st == 1 && g) m_st = 2;
         m_el++;
      end
   endtask

   task automatic session(input int gw, input int ew, input bit stray, input string ctx);
      int k = 0;
      cyc(1, 0, 0, 8'h00, 0, ctx);
      while (m_st != 0 && k < LIM + 5) begin
         logic s = stray && ($urandom_range(0, 5) == 0);
         if (m_st == 1)
            cyc(s, k >= gw, $urandom_range(0, 1), 8'($urandom), 0, ctx);
         else
            cyc(s, $urandom_range(0, 1), $urandom_range(0, 1), 8'($urandom), k >= ew, ctx);
         k++;
      end
   endtask

   initial begin
      #(8 * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      int tcnt;
      void'($urandom(32'd20240611));
      // R1: outputs low during reset even with activity on the inputs
      @(negedge clk);
      start_i = 1; grant_i = 1; byte_vld_i = 1; byte_i = 8'hA5; end_i = 1;
      #1;
      chk1(req_o | byte_vld_o | done_o | timeout_o, 1'b0, "R1", "in reset");
      chk1(byte_o == 8'h00, 1'b1, "R1", "byte in reset");
      @(negedge clk);
      start_i = 0; grant_i = 0; byte_vld_i = 0; end_i = 0;
      rst_n = 1;
      cyc(0, 0, 0, 8'h00, 0, "R1 idle after reset");
      // R10: grant, end and bytes while idle
      for (int i = 0; i < 6; i++) cyc(0, 1, 1, 8'h3C + 8'(i), i[0], "R10 idle noise");
      // R2/R3/R4: a short directed session
      cyc(1, 0, 0, 8'h00, 0, "R2 start");
      cyc(0, 0, 1, 8'h11, 0, "R2 req held, R3 no fwd in req");
      cyc(0, 1, 0, 8'h00, 0, "R2 grant cycle");
      cyc(0, 0, 1, 8'hC3, 0, "R3 fwd");
      cyc(0, 0, 1, 8'h7E, 0, "R3 fwd");
      cyc(0, 0, 0, 8'h55, 0, "R9 gap");
      cyc(0, 0, 1, 8'h99, 1, "R4 end drops byte");
      cyc(0, 0, 1, 8'h42, 0, "R4 idle after done");
      // R5/R8: no grant ever, measure the limit at the ports
      cyc(1, 0, 0, 8'h00, 0, "R8 start");
      tcnt = 0;
      while (m_st != 0 && tcnt < LIM + 5) begin
         cyc(0, 0, 0, 8'h00, 0, "R5 waiting");
         tcnt++;
      end
      chk1(tcnt == LIM, 1'b1, "R8", "cycles until timeout");
      // R6: end lands on the limit cycle
      cyc(1, 0, 0, 8'h00, 0, "R6 start");
      cyc(0, 1, 0, 8'h00, 0, "R6 grant");
      for (int i = 1; i < LIM - 1; i++) cyc(0, 0, 1, 8'(i), 0, "R6 stream");
      cyc(0, 0, 1, 8'hEE, 1, "R6 end with timeout");
      chk1(m_st == 0, 1'b1, "R6", "model back to idle");
      // R7: restart attempts inside a session do not reload the timer
      cyc(1, 0, 0, 8'h00, 0, "R7 start");
      for (int i = 0; i < LIM + 2; i++) cyc(i == 20 || i == 30, i == 5, 1, 8'(i * 3), 0, "R7 stray start");
      // randomised sessions
      for (int n = 0; n < 120; n++)
         session($urandom_range(0, 45), $urandom_range(0, 45), 1'b1, "random");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule